// File: doc/BRIEF.md
# Random Number Controller Register Block

This block is the register front end of a random number peripheral. Software reaches it over a small word-oriented register bus. It can read an identification word and start two background operations, seeding and self-test. It can also set interrupt masks and an auto-seed flag, poll a status word, and pull 32-bit random words from a data address.

Seeding and self-test are each followed by their own three-state tracker (idle, running, done). A started operation stays running for a parameterised number of cycles and then settles in done. Its completion raises a level interrupt unless completion interrupts are masked. Random words come from an internal 32-bit xorshift generator that advances by one step on each data read. This is a model of an entropy source for integration and software bring-up, not a real one.

Top module: `rng_regs`

## Requirements
- R1: A read of offset 0x00 returns 0x1000_0240 (type 1 in bits 31:28, major 0x2 in bits 15:8, minor 0x40 in bits 7:0).
- R2: A write to offset 0x08 stores bit 6 (mask-error), bit 5 (mask-done) and bit 4 (auto-seed). A read of 0x08 returns exactly those stored bits, and every other bit reads as zero.
- R3: Writing offset 0x04 with bit 1 set starts seeding, and with bit 0 set starts self-test. A started operation is running for SEED_CYCLES or TEST_CYCLES clock cycles after the accepting edge and then becomes done. A new start while running restarts the count.
- R4: A read of offset 0x04 returns bit 1 while seeding runs and bit 0 while self-test runs, and zero in all other bits.
- R5: A read of offset 0x0C returns bits 14:12 = 5, bits 11:8 = 5 and bit 6 = 1 at all times. Bit 5 is set when seeding is done and bit 4 when self-test is done. Bit 1 is set while either operation runs; otherwise bit 0 is set. All other bits read as zero.
- R6: `irq` rises on the edge where an operation becomes done, unless mask-done is set at that moment. A command write with bit 5 or bit 4 set clears it. When a completion and a clear fall on the same edge, the completion wins and `irq` stays high.
- R7: A command write with bit 6 set returns both trackers to idle and clears all control bits. It does not touch `irq`. Start bits in the same write still take effect.
- R8: Each read of offset 0x14 returns the current generator word and then advances it by one xorshift step (x ^= x<<13; x ^= x>>17; x ^= x<<5). After reset the generator holds SEED.
- R9: A read of any other offset returns zero, and a write to any offset other than 0x04 and 0x08 changes nothing.
- R10: A transfer is accepted on an edge where `bus_req` is high and `bus_ack` is low. `bus_ack` is then high for exactly one cycle, with `bus_rdata` valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Transfer request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle transfer acknowledge |
| irq | output | 1 | Level completion interrupt |

## Verification
Two events can land on the same clock edge: an operation finishing and software clearing the interrupt. The bench starts a seed operation and times a clear-interrupt write so that it is accepted on exactly the edge where the seed count expires. It then expects `irq` to be high afterwards, because the completion must not be lost. A second, separate clear must then bring `irq` low. A soft reset that arrives together with a start bit is covered in the same spirit: the start must survive the reset.

// File: rtl/rng_regs_pkg.sv
package rng_regs_pkg;
  localparam logic [7:0] OFF_VER    = 8'h00;
  localparam logic [7:0] OFF_CMD    = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_STAT   = 8'h0C;
  localparam logic [7:0] OFF_RAND   = 8'h14;

  localparam int CMD_SOFT_RST = 6;
  localparam int CMD_CLR_ERR  = 5;
  localparam int CMD_CLR_IRQ  = 4;
  localparam int CMD_SEED     = 1;
  localparam int CMD_TEST     = 0;

  localparam logic [31:0] CTRL_KEEP = 32'h0000_0070;
  localparam int CTRL_MASK_DONE = 5;

  localparam logic [31:0] ID_WORD = 32'h1000_0240;

  typedef enum logic [1:0] {OP_IDLE, OP_RUN, OP_DONE} op_state_e;
endpackage

// File: rtl/rng_op_tracker.sv
module rng_op_tracker
  import rng_regs_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      clear,
  output logic      finish,
  output op_state_e state
);
  localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

  op_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    finish = 1'b0;
    if (start) begin
      st_d  = OP_RUN;
      cnt_d = '0;
    end else if (clear) begin
      st_d  = OP_IDLE;
      cnt_d = '0;
    end else if (st_q == OP_RUN) begin
      if (cnt_q == LAST) begin
        st_d   = OP_DONE;
        finish = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OP_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/rng_xorshift.sv
module rng_xorshift #(
  parameter logic [31:0] SEED = 32'h2545_F491
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [31:0] value
);
  logic [31:0] x_q, x_d, t1, t2;

  always_comb begin
    t1  = x_q ^ (x_q << 13);
    t2  = t1 ^ (t1 >> 17);
    x_d = adv ? (t2 ^ (t2 << 5)) : x_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_q <= SEED;
    else        x_q <= x_d;
  end

  assign value = x_q;
endmodule

// File: rtl/rng_regs.sv
module rng_regs
  import rng_regs_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          SEED_CYCLES = 20,
  parameter int          TEST_CYCLES = 12,
  parameter logic [31:0] SEED        = 32'h2545_F491
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              irq
);
  logic        ack_q, irq_q, irq_d;
  logic [31:0] rdata_q, rdata_d, ctrl_q, ctrl_d, rd_mux, rnd;
  logic        accept, wr, rd;
  logic        hit_ver, hit_cmd, hit_ctrl, hit_stat, hit_rand;
  logic        cmd_wr, soft_rst, seed_go, test_go, irq_clr;
  logic        seed_fin, test_fin, mask_done, busy;
  op_state_e   seed_st, test_st;
  logic        unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:7], bus_wdata[3:2]};

  assign accept   = bus_req & ~ack_q;
  assign wr       = accept & bus_we;
  assign rd       = accept & ~bus_we;
  assign hit_ver  = (bus_addr == ADDR_W'(OFF_VER));
  assign hit_cmd  = (bus_addr == ADDR_W'(OFF_CMD));
  assign hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
  assign hit_rand = (bus_addr == ADDR_W'(OFF_RAND));

  assign cmd_wr   = wr & hit_cmd;
  assign soft_rst = cmd_wr & bus_wdata[CMD_SOFT_RST];
  assign seed_go  = cmd_wr & bus_wdata[CMD_SEED];
  assign test_go  = cmd_wr & bus_wdata[CMD_TEST];
  assign irq_clr  = cmd_wr & (bus_wdata[CMD_CLR_ERR] | bus_wdata[CMD_CLR_IRQ]);
  assign mask_done = ctrl_q[CTRL_MASK_DONE];

  rng_op_tracker #(.BUSY_CYCLES(SEED_CYCLES)) u_seed (
    .clk(clk), .rst_n(rst_n), .start(seed_go), .clear(soft_rst),
    .finish(seed_fin), .state(seed_st)
  );

  rng_op_tracker #(.BUSY_CYCLES(TEST_CYCLES)) u_test (
    .clk(clk), .rst_n(rst_n), .start(test_go), .clear(soft_rst),
    .finish(test_fin), .state(test_st)
  );

  rng_xorshift #(.SEED(SEED)) u_gen (
    .clk(clk), .rst_n(rst_n), .adv(rd & hit_rand), .value(rnd)
  );

  assign busy = (seed_st == OP_RUN) | (test_st == OP_RUN);

  always_comb begin
    rd_mux = '0;
    if (hit_ver)  rd_mux = ID_WORD;
    if (hit_cmd)  rd_mux = {30'd0, seed_st == OP_RUN, test_st == OP_RUN};
    if (hit_ctrl) rd_mux = ctrl_q;
    if (hit_stat) rd_mux = {17'd0, 3'd5, 4'd5, 1'b0, 1'b1,
                            seed_st == OP_DONE, test_st == OP_DONE,
                            2'b00, busy, ~busy};
    if (hit_rand) rd_mux = rnd;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (soft_rst)              ctrl_d = '0;
    else if (wr && hit_ctrl)   ctrl_d = bus_wdata & CTRL_KEEP;
    irq_d = irq_q;
    if ((seed_fin || test_fin) && !mask_done) irq_d = 1'b1;
    else if (irq_clr)                         irq_d = 1'b0;
    rdata_d = rdata_q;
    if (accept) rdata_d = bus_we ? 32'd0 : rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      irq_q   <= 1'b0;
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      ack_q   <= accept;
      irq_q   <= irq_d;
      ctrl_q  <= ctrl_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/rng_regs_chk.sv
module rng_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_ack,
  input logic              irq,
  input logic              seed_fin,
  input logic              test_fin,
  input logic              mask_done
);
  logic rd_cmd, rd_stat, rd_ver;
  assign rd_cmd  = bus_req && !bus_ack && !bus_we && bus_addr == ADDR_W'(8'h04);
  assign rd_stat = bus_req && !bus_ack && !bus_we && bus_addr == ADDR_W'(8'h0C);
  assign rd_ver  = bus_req && !bus_ack && !bus_we && bus_addr == ADDR_W'(8'h00);

  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  a_r10_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_ack);

  a_r6_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(seed_fin || test_fin));

  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$past(mask_done));

  a_r4_cmd_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> bus_rdata[31:2] == 30'd0);

  a_r5_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (bus_rdata[14:8] == 7'h55 && bus_rdata[6] &&
                 (bus_rdata[1] ^ bus_rdata[0])));

  a_r1_id_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ver |=> bus_rdata == 32'h1000_0240);
endmodule

bind rng_regs rng_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq),
  .seed_fin(seed_fin), .test_fin(test_fin), .mask_done(mask_done)
);

// File: tb/sim_rng_regs.sv
module sim_rng_regs;
  localparam int SEEDC = 20;
  localparam int TESTC = 12;
  localparam logic [31:0] GSEED = 32'h2545_F491;

  logic        clk, rst_n, bus_req, bus_we, bus_ack, irq;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int tests, fails;
  logic last_rd;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model;

  rng_regs #(.ADDR_W(8), .SEED_CYCLES(SEEDC), .TEST_CYCLES(TESTC), .SEED(GSEED)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; last_rd = 1'b0;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; last_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  // monitor: pops expectations as read acknowledges appear
  always @(negedge clk) begin
    if (rst_n && bus_ack && last_rd) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R10 actual=unexpected ack expected=none");
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tests = 0; fails = 0; last_rd = 1'b0;
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 reset irq", {31'd0, irq}, 32'd0);
    check("R10 reset ack", {31'd0, bus_ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: ack exactly one cycle
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h00; last_rd = 1'b0;
    @(negedge clk);
    check("R10 ack high", {31'd0, bus_ack}, 32'd1);
    check("R10 rdata with ack", bus_rdata, 32'h1000_0240);
    bus_req = 1'b0;
    @(negedge clk);
    check("R10 ack low", {31'd0, bus_ack}, 32'd0);

    bus_read(8'h00, 32'h1000_0240, "R1 id word");
    bus_read(8'h0C, 32'h0000_5541, "R5 idle status");
    bus_read(8'h08, 32'h0, "R2 ctrl reset");
    bus_read(8'h04, 32'h0, "R4 cmd idle");

    // R2 control storage
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_read(8'h08, 32'h0000_0070, "R2 ctrl all ones");
    bus_write(8'h08, 32'h0000_0010);
    bus_read(8'h08, 32'h0000_0010, "R2 ctrl auto-seed only");
    bus_write(8'h08, 32'h0);

    // R3/R4/R5 seeding
    bus_write(8'h04, 32'h2);
    bus_read(8'h04, 32'h2, "R4 cmd seed running");
    bus_read(8'h0C, 32'h0000_5542, "R5 busy status");
    repeat (SEEDC + 5) @(negedge clk);
    bus_read(8'h0C, 32'h0000_5561, "R5 seed done status");
    bus_read(8'h04, 32'h0, "R4 cmd after seed");
    check("R6 irq after seed", {31'd0, irq}, 32'd1);
    bus_write(8'h04, 32'h10);
    check("R6 clear-int", {31'd0, irq}, 32'd0);

    // R3 exact duration
    bus_write(8'h04, 32'h2);
    repeat (SEEDC - 1) @(negedge clk);
    check("R3 still running", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R3 done on time", {31'd0, irq}, 32'd1);
    bus_write(8'h04, 32'h20);
    check("R6 clear-err", {31'd0, irq}, 32'd0);

    // R6 masked completion
    bus_write(8'h08, 32'h20);
    bus_write(8'h04, 32'h1);
    repeat (TESTC + 5) @(negedge clk);
    check("R6 masked no irq", {31'd0, irq}, 32'd0);
    bus_read(8'h0C, 32'h0000_5571, "R5 both done");
    bus_write(8'h08, 32'h0);

    // R3 restart
    bus_write(8'h04, 32'h2);
    repeat (8) @(negedge clk);
    bus_write(8'h04, 32'h2);
    repeat (SEEDC - 1) @(negedge clk);
    check("R3 restart holds", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R3 restart done", {31'd0, irq}, 32'd1);
    bus_write(8'h04, 32'h10);

    // R6 finish and clear on the same edge
    bus_write(8'h04, 32'h2);
    repeat (SEEDC - 2) @(negedge clk);
    bus_write(8'h04, 32'h10);
    check("R6 finish beats clear", {31'd0, irq}, 32'd1);
    bus_write(8'h04, 32'h10);
    check("R6 later clear", {31'd0, irq}, 32'd0);

    // R7 soft reset
    bus_write(8'h04, 32'h2);
    repeat (SEEDC + 3) @(negedge clk);
    bus_write(8'h08, 32'h70);
    bus_write(8'h04, 32'h1);
    bus_write(8'h04, 32'h40);
    check("R7 irq untouched", {31'd0, irq}, 32'd1);
    bus_read(8'h08, 32'h0, "R7 ctrl cleared");
    bus_read(8'h04, 32'h0, "R7 cmd idle");
    bus_read(8'h0C, 32'h0000_5541, "R7 status idle");
    bus_write(8'h04, 32'h10);
    bus_write(8'h04, 32'h42);
    bus_read(8'h04, 32'h2, "R7 start survives reset");
    repeat (SEEDC + 3) @(negedge clk);
    check("R7 unmasked after reset", {31'd0, irq}, 32'd1);
    bus_write(8'h04, 32'h10);

    // R8 random words
    model = GSEED;
    for (int i = 0; i < 4; i++) begin
      bus_read(8'h14, model, "R8 random word");
      model = xs(model);
    end

    // R9 unmapped
    bus_read(8'h10, 32'h0, "R9 unmapped 0x10");
    bus_read(8'h18, 32'h0, "R9 unmapped 0x18");
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h14, 32'hFFFF_FFFF);
    bus_read(8'h08, 32'h0, "R9 ctrl unchanged");
    bus_read(8'h0C, 32'h0000_5561, "R9 status unchanged");
    bus_read(8'h14, model, "R9 generator unchanged by write");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R10 actual=%0d pending expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule